// File: doc/BRIEF.md
# Shared Product Term Allocator

This block takes the standard product terms of one logic block and turns them into one sum-of-products signal for each macrocell. It works as a segmented OR array. A stored configuration mask for each macrocell names the product terms that macrocell ORs together. Each term is steered on its own, with no clusters. One term may feed several macrocells at the same time, and a macrocell may select no terms at all.

Macrocell `i` reaches a sliding window of `WIN` terms that starts at term `STEP*i`. With the defaults this is terms 4i to 4i+19, so the last window ends on the last term. At most `MAX_PT` terms (16) may be active in a window. A macrocell can be put in input mode, where it is given no terms. Each macrocell reads its terms through a balanced OR tree of the same depth as every other macrocell, so the delay does not depend on how many terms are used.

Configuration is written one macrocell at a time through a synchronous write port. A per-macrocell legality flag reports masks that the allocator cannot honour.

Top module: `pta_alloc`

## Requirements
- R1: While `rst_ni` is low, and after it rises, every mask is zero and every macrocell is in normal mode. So `sum_o` and `range_err_o` are all zero, whatever `pterm_i` holds.
- R2: In normal mode, `sum_o[i]` is the OR over j in [4i, 4i+19] of `pterm_i[j] & mask[i][j]`. Bit j of a mask refers to absolute term j.
- R3: A macrocell whose mask selects no term in its window outputs 0.
- R4: One product term selected by several macrocells drives all of their outputs at the same time.
- R5: Mask bits outside a macrocell's window have no effect on its `sum_o` bit.
- R6: In normal mode, `range_err_o[i]` is 1 when the mask has any bit set outside the window, or more than 16 bits set inside it. Exactly 16 bits set inside the window is legal.
- R7: In input mode (`cfg_mode_i`=1 at write), `sum_o[i]` is 0 whatever the mask holds, and `range_err_o[i]` is 1 if any mask bit is set.
- R8: A rising clock edge with `cfg_we_i`=1 replaces the mask and mode of macrocell `cfg_sel_i` only. The new configuration takes effect right after that edge. With `cfg_we_i`=0 the configuration does not change.
- R9: `sum_o` follows `pterm_i` combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration write port |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for one macrocell configuration |
| cfg_sel_i | input | 4 | Index of the macrocell being written |
| cfg_mode_i | input | 1 | 1 = input mode (no terms), 0 = normal |
| cfg_mask_i | input | 80 | Term mask; bit j selects absolute term j |
| pterm_i | input | 80 | Product terms from the AND array |
| sum_o | output | 16 | Sum-of-products, one per macrocell |
| range_err_o | output | 16 | Per-macrocell legality flag |

## Verification
Single-term patterns at the low and high ends of overlapping windows separate correct steering from off-by-one window placement. A term sitting just outside a window, and one sitting at the top of the last window, separate real window limits from plain mask decoding. A term selected by three macrocells shows that sharing works. Terms under an input-mode macrocell and under a macrocell with 17 selected terms test the forcing to zero and the count limit. The all-ones pattern shows the OR union. Rewriting one macrocell, and holding a write with the strobe low, show that a write changes only the macrocell it selects, and only when the strobe is high.

// File: rtl/pta_pkg.sv
package pta_pkg;
  localparam int PT_NUM   = 80;
  localparam int MC_NUM   = 16;
  localparam int WIN_LEN  = 20;
  localparam int WIN_STEP = 4;
  localparam int PT_MAX   = 16;
endpackage

// File: rtl/pta_cfg_store.sv
module pta_cfg_store #(
  parameter int N_PT = 80,
  parameter int N_MC = 16,
  localparam int SEL_W = $clog2(N_MC)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic                       mode_i,
  input  logic [N_PT-1:0]            mask_i,
  output logic [N_MC-1:0][N_PT-1:0]  mask_o,
  output logic [N_MC-1:0]            mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      mode_o <= '0;
    end else if (we_i) begin
      for (int k = 0; k < N_MC; k++) begin
        if (sel_i == SEL_W'(k)) begin
          mask_o[k] <= mask_i;
          mode_o[k] <= mode_i;
        end
      end
    end
  end
endmodule

// File: rtl/pta_window.sv
module pta_window #(
  parameter int N_PT   = 80,
  parameter int WIN    = 20,
  parameter int BASE   = 0,
  parameter int MAX_PT = 16,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic [N_PT-1:0] mask_i,
  input  logic            mode_i,
  input  logic [WIN-1:0]  pt_i,
  output logic [WIN-1:0]  hit_o,
  output logic            err_o
);
  localparam logic [N_PT-1:0] WMASK = N_PT'({WIN{1'b1}}) << BASE;

  function automatic logic [CNT_W-1:0] popc(input logic [WIN-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int k = 0; k < WIN; k++) c = c + CNT_W'(v[k]);
    return c;
  endfunction

  logic [WIN-1:0] in_win;
  logic           out_bits;
  logic           too_many;

  assign in_win   = mask_i[BASE +: WIN];
  assign out_bits = |(mask_i & ~WMASK);
  assign too_many = popc(in_win) > CNT_W'(MAX_PT);

  // input mode takes no terms; any set bit is illegal
  assign hit_o = mode_i ? '0 : (in_win & pt_i);
  assign err_o = mode_i ? (|mask_i) : (out_bits | too_many);
endmodule

// File: rtl/pta_or_tree.sv
module pta_or_tree #(
  parameter int W = 20,
  localparam int LV = (W > 1) ? $clog2(W) : 0,
  localparam int P  = 1 << LV
) (
  input  logic [W-1:0] in_i,
  output logic         out_o
);
  // heap layout: leaves at P-1 .. 2P-2, root at 0; every leaf is LV levels deep
  logic [2*P-2:0] node;

  for (genvar k = 0; k < P; k++) begin : g_leaf
    if (k < W) begin : g_used
      assign node[P-1+k] = in_i[k];
    end else begin : g_pad
      assign node[P-1+k] = 1'b0;
    end
  end

  for (genvar j = 0; j < P - 1; j++) begin : g_node
    assign node[j] = node[2*j+1] | node[2*j+2];
  end

  assign out_o = node[0];
endmodule

// File: rtl/pta_alloc.sv
module pta_alloc
  import pta_pkg::*;
#(
  parameter int N_PT   = PT_NUM,
  parameter int N_MC   = MC_NUM,
  parameter int WIN    = WIN_LEN,
  parameter int STEP   = WIN_STEP,
  parameter int MAX_PT = PT_MAX,
  localparam int SEL_W = $clog2(N_MC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic              cfg_mode_i,
  input  logic [N_PT-1:0]   cfg_mask_i,
  input  logic [N_PT-1:0]   pterm_i,
  output logic [N_MC-1:0]   sum_o,
  output logic [N_MC-1:0]   range_err_o
);
  logic [N_MC-1:0][N_PT-1:0] mask_q;
  logic [N_MC-1:0]           mode_q;

  pta_cfg_store #(.N_PT(N_PT), .N_MC(N_MC)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .sel_i  (cfg_sel_i),
    .mode_i (cfg_mode_i),
    .mask_i (cfg_mask_i),
    .mask_o (mask_q),
    .mode_o (mode_q)
  );

  for (genvar g = 0; g < N_MC; g++) begin : g_mc
    localparam int BASE = g * STEP;
    logic [WIN-1:0] hit;

    pta_window #(.N_PT(N_PT), .WIN(WIN), .BASE(BASE), .MAX_PT(MAX_PT)) i_win (
      .mask_i (mask_q[g]),
      .mode_i (mode_q[g]),
      .pt_i   (pterm_i[BASE +: WIN]),
      .hit_o  (hit),
      .err_o  (range_err_o[g])
    );

    pta_or_tree #(.W(WIN)) i_or (
      .in_i  (hit),
      .out_o (sum_o[g])
    );
  end
endmodule

// File: rtl/pta_alloc_chk.sv
module pta_alloc_chk #(
  parameter int N_PT = 80,
  parameter int N_MC = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cfg_we_i,
  input logic [N_PT-1:0]           pterm_i,
  input logic [N_MC-1:0]           sum_o,
  input logic [N_MC-1:0]           range_err_o,
  input logic [N_MC-1:0][N_PT-1:0] mask_q,
  input logic [N_MC-1:0]           mode_q
);
  // R7
  input_mode_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_o & mode_q) == '0);

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(range_err_o));

  for (genvar i = 0; i < N_MC; i++) begin : g_chk
    // R2
    sum_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sum_o[i] |-> |(pterm_i & mask_q[i]));

    // R3
    empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q[i] == '0) |-> !sum_o[i]);

    // R6
    err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      range_err_o[i] |-> (mask_q[i] != '0));
  end
endmodule

bind pta_alloc pta_alloc_chk #(.N_PT(N_PT), .N_MC(N_MC)) i_pta_alloc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .pterm_i     (pterm_i),
  .sum_o       (sum_o),
  .range_err_o (range_err_o),
  .mask_q      (mask_q),
  .mode_q      (mode_q)
);

// File: tb/test_pta_alloc.sv
module test_pta_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic        cfg_mode = 1'b0;
  logic [79:0] cfg_mask = '0;
  logic [79:0] pterm = '0;
  logic [15:0] sum;
  logic [15:0] err;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pta_alloc i_pta_alloc (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_mode_i(cfg_mode), .cfg_mask_i(cfg_mask), .pterm_i(pterm),
    .sum_o(sum), .range_err_o(err)
  );

  localparam int NV = 11;
  localparam logic [79:0] PT_V [NV] = '{
    80'd0, 80'd1 << 0, 80'd1 << 15, 80'd1 << 4, 80'd1 << 30, 80'd1 << 59,
    80'd1 << 79, {80{1'b1}}, (80'd1 << 8) | (80'd1 << 12), 80'd1 << 32, 80'd1 << 33
  };
  localparam logic [15:0] EXP_V [NV] = '{
    16'h0000, 16'h0001, 16'h000D, 16'h0002, 16'h0010, 16'h0000,
    16'h8000, 16'h801F, 16'h000C, 16'h0010, 16'h0000
  };
  localparam string TAG_V [NV] = '{
    "R3", "R5", "R4", "R2", "R7", "R5", "R2", "R2", "R4", "R6", "R2"
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic mode, input logic [79:0] mask, input logic we);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_mode = mode; cfg_mask = mask;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [79:0] bits(input int lo, input int hi);
    logic [79:0] v = '0;
    for (int k = lo; k <= hi; k++) v[k] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    pterm = '1;
    #3;
    chk("R1 sum in reset", sum, 16'h0000);
    chk("R1 err in reset", err, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 sum after reset", sum, 16'h0000);

    wr(4'd0,  1'b0, (80'd1 << 0) | (80'd1 << 15), 1'b1);
    wr(4'd1,  1'b0, (80'd1 << 4) | (80'd1 << 0), 1'b1);
    wr(4'd2,  1'b0, (80'd1 << 8) | (80'd1 << 15), 1'b1);
    wr(4'd3,  1'b0, (80'd1 << 12) | (80'd1 << 15), 1'b1);
    wr(4'd4,  1'b0, bits(16, 32), 1'b1);
    wr(4'd7,  1'b1, 80'd1 << 30, 1'b1);
    wr(4'd15, 1'b0, (80'd1 << 75) | (80'd1 << 79) | (80'd1 << 59), 1'b1);
    #1;
    chk("R6 err flags", err, 16'h8092);

    // R9: combinational walk, no clock edges awaited
    for (int k = 0; k < NV; k++) begin
      pterm = PT_V[k];
      #1;
      chk(TAG_V[k], sum, EXP_V[k]);
    end

    // R8: strobe low leaves mc0 untouched
    wr(4'd0, 1'b0, '0, 1'b0);
    pterm = 80'd1 << 0; #1;
    chk("R8 no write when strobe low", sum, 16'h0001);

    // R8: write mc5 only
    wr(4'd5, 1'b0, 80'd1 << 39, 1'b1);
    pterm = (80'd1 << 39) | (80'd1 << 15); #1;
    chk("R8 new mask and others kept", sum, 16'h002D);

    // R7 / R8: mc7 back to normal mode
    wr(4'd7, 1'b0, 80'd1 << 30, 1'b1);
    pterm = 80'd1 << 30; #1;
    chk("R7 leave input mode", sum, 16'h0090);
    chk("R7 err cleared", err, 16'h8012);

    // R6: exactly 16 in-window terms is legal
    wr(4'd4, 1'b0, bits(16, 31), 1'b1);
    #1;
    chk("R6 sixteen terms legal", err, 16'h8002);
    pterm = 80'd1 << 32; #1;
    chk("R2 dropped term", sum, 16'h0000);

    // R1: asynchronous reset clears configuration
    @(negedge clk); rst_n = 1'b0; pterm = '1; #1;
    chk("R1 sum after async reset", sum, 16'h0000);
    chk("R1 err after async reset", err, 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule